// File: doc/BRIEF.md
# MSI Indicator Bit Interrupt Router

This block takes a message-signalled interrupt write coming from a device and turns it into two bit-set operations on indicator arrays that live in memory: one bit in the device's own per-vector indicator array and one bit in a summary array shared by many devices. Both bit sets go through a byte-wide atomic OR port. The port hands back the byte as it was before the OR. When the summary byte was entirely clear before the OR, nobody has yet been told that work is pending, so the block raises an adapter interrupt request that carries the device's interruption subclass.

The incoming data word is split into a device index in its upper bits and a vector number in its lower bits. If no device is mapped at that index, no bits are set and an error event is produced instead. If the device exists but is not enabled, the write is dropped silently. A failed access through the OR port also produces an error event, with a different status code. Reads of the control window always return all ones.

Inside each byte, bits are numbered from the most significant bit down. Bit number n of an array therefore lives in byte n/8, under mask 0x80 shifted right by n mod 8.

Top module: `msi_bit_router`

## Requirements
- R1: The write data is split at bit VEC_BITS (default 11). The vector is `wr_data[VEC_BITS-1:0]` and the device index is `wr_data[DATA_W-1:VEC_BITS]`.
- R2: When `dev_present` is low, an accepted write starts no OR operation. One cycle later it pulses `err_valid` with `err_code` = NOMSI_CODE (default 16'h0001), `err_handle` = index, `err_addr` = `wr_addr` and `err_detail` = vector shifted left by VEC_SHIFT (default 16).
- R3: When `dev_present` is high and `dev_enabled` is low, an accepted write starts no OR operation and produces no error event and no interrupt.
- R4: The indicator OR targets byte `ind_base + ((ind_off + vector) >> 3)` with mask `8'h80 >> ((ind_off + vector) % 8)`.
- R5: The summary OR targets byte `sum_base + (sum_off >> 3)` with mask `8'h80 >> (sum_off % 8)`.
- R6: The indicator OR is issued first. `rmw_req`, `rmw_addr` and `rmw_mask` are held steady until `rmw_ack`. The summary OR is issued only after the indicator acknowledge.
- R7: One cycle after the summary acknowledge, `irq_valid` pulses with `irq_isc` equal to the device's subclass. This happens only if that acknowledge had `rmw_err` low and `rmw_old` equal to zero.
- R8: An acknowledge with `rmw_err` high produces, one cycle later, an error event with `err_code` = AIRERR_CODE (default 16'h0002) and zero handle, address and detail. A failed indicator OR still continues to the summary OR. A failed summary OR raises no interrupt.
- R9: `busy` is high from the cycle after an enabled write is accepted until the summary acknowledge. Writes presented while `busy` is high are ignored.
- R10: A pulse on `rd_en` gives `rd_valid` high one cycle later, with `rd_data` all ones.
- R11: After reset, `rmw_req`, `irq_valid`, `err_valid`, `rd_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | MSI data write strobe |
| wr_addr | input | ADDR_W | Address of the MSI write |
| wr_data | input | DATA_W | MSI write data (index and vector) |
| rd_en | input | 1 | Read strobe for the control window |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | RD_W | Read data (all ones) |
| dev_present | input | 1 | A device is mapped for this write |
| dev_enabled | input | 1 | The mapped device is enabled |
| ind_base | input | ADDR_W | Indicator array base byte address |
| ind_off | input | OFF_W | Indicator bit offset |
| sum_base | input | ADDR_W | Summary array base byte address |
| sum_off | input | OFF_W | Summary bit offset |
| isc | input | ISC_W | Interruption subclass of the device |
| busy | output | 1 | A bit-set sequence is in progress |
| rmw_req | output | 1 | Atomic OR request |
| rmw_addr | output | ADDR_W | Byte address of the OR |
| rmw_mask | output | 8 | One-hot OR mask |
| rmw_ack | input | 1 | OR complete |
| rmw_old | input | 8 | Byte value before the OR |
| rmw_err | input | 1 | OR access failed |
| irq_valid | output | 1 | Adapter interrupt request pulse |
| irq_isc | output | ISC_W | Subclass carried by the request |
| err_valid | output | 1 | Error event push |
| err_code | output | 16 | Error status code |
| err_handle | output | DATA_W-VEC_BITS | Handle (device index) |
| err_addr | output | ADDR_W | Faulting write address |
| err_detail | output | 32 | Error detail word |

## Verification
The bench checks the interrupt rule at both edges. A summary byte that is already set must raise no request; a design that tested the new byte or the mask would interrupt on every write. Bit numbers that land on bit 7 of a byte and that cross into the next byte are exercised; a design using LSB-first numbering or forgetting the division would hit the wrong mask or address. Faults on the indicator access and on the summary access are injected separately. A design that aborted after an indicator fault would lose the summary OR, and one that ignored a summary fault would raise an interrupt. Missing-device, disabled-device and busy-time writes are all checked to cause nothing beyond what the requirements name.

// File: rtl/msi_rt_pkg.sv
package msi_rt_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_IND  = 2'd1,
      SEQ_SUM  = 2'd2
   } seq_state_t;

   // MSB-first bit numbering inside a byte
   function automatic logic [7:0] msb_first_mask(input logic [2:0] pos);
      return 8'h80 >> pos;
   endfunction

endpackage

// File: rtl/msi_rt_split.sv
module msi_rt_split #(
   parameter int DATA_W   = 32,
   parameter int VEC_BITS = 11,
   localparam int IDX_W   = DATA_W - VEC_BITS
) (
   input  logic [DATA_W-1:0]   data,
   output logic [IDX_W-1:0]    idx,
   output logic [VEC_BITS-1:0] vec
);
   assign idx = data[DATA_W-1:VEC_BITS];
   assign vec = data[VEC_BITS-1:0];
endmodule

// File: rtl/msi_rt_locate.sv
module msi_rt_locate
   import msi_rt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int VEC_BITS = 11,
   parameter bit ADD_VEC  = 1'b1,
   localparam int NUM_W   = ((OFF_W > VEC_BITS) ? OFF_W : VEC_BITS) + 1
) (
   input  logic [ADDR_W-1:0]   base,
   input  logic [OFF_W-1:0]    off,
   input  logic [VEC_BITS-1:0] vec,
   output logic [ADDR_W-1:0]   byte_addr,
   output logic [7:0]          mask
);
   logic [NUM_W-1:0] bit_num;

   generate
      if (ADD_VEC) begin : g_with_vec
         assign bit_num = NUM_W'(off) + NUM_W'(vec);
      end else begin : g_off_only
         logic unused_vec;
         assign unused_vec = ^vec;
         assign bit_num    = NUM_W'(off);
      end
   endgenerate

   assign byte_addr = base + ADDR_W'(bit_num >> 3);
   assign mask      = msb_first_mask(bit_num[2:0]);
endmodule

// File: rtl/msi_rt_seq.sv
module msi_rt_seq
   import msi_rt_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 21,
   parameter int VEC_BITS    = 11,
   parameter int ISC_W       = 3,
   parameter int DET_W       = 32,
   parameter int VEC_SHIFT   = 16,
   parameter logic [15:0] NOMSI_CODE  = 16'h0001,
   parameter logic [15:0] AIRERR_CODE = 16'h0002
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [IDX_W-1:0]    idx,
   input  logic [VEC_BITS-1:0] vec,
   input  logic                dev_present,
   input  logic                dev_enabled,
   input  logic [ADDR_W-1:0]   ind_addr,
   input  logic [7:0]          ind_mask,
   input  logic [ADDR_W-1:0]   sum_addr,
   input  logic [7:0]          sum_mask,
   input  logic [ISC_W-1:0]    isc,
   output logic                busy,
   output logic                rmw_req,
   output logic [ADDR_W-1:0]   rmw_addr,
   output logic [7:0]          rmw_mask,
   input  logic                rmw_ack,
   input  logic [7:0]          rmw_old,
   input  logic                rmw_err,
   output logic                irq_valid,
   output logic [ISC_W-1:0]    irq_isc,
   output logic                err_valid,
   output logic [15:0]         err_code,
   output logic [IDX_W-1:0]    err_handle,
   output logic [ADDR_W-1:0]   err_addr,
   output logic [DET_W-1:0]    err_detail
);
   seq_state_t          state_q, state_d;
   logic [ADDR_W-1:0]   ind_addr_q, sum_addr_q;
   logic [7:0]          ind_mask_q, sum_mask_q;
   logic [ISC_W-1:0]    isc_q;
   logic                accept, start_seq, no_dev, step_done;

   assign accept    = wr_valid && (state_q == SEQ_IDLE);
   assign no_dev    = accept && !dev_present;
   assign start_seq = accept && dev_present && dev_enabled;
   assign step_done = rmw_req && rmw_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (start_seq) state_d = SEQ_IND;
         SEQ_IND:  if (step_done) state_d = SEQ_SUM;
         SEQ_SUM:  if (step_done) state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   assign busy     = (state_q != SEQ_IDLE);
   assign rmw_req  = busy;
   assign rmw_addr = (state_q == SEQ_SUM) ? sum_addr_q : ind_addr_q;
   assign rmw_mask = (state_q == SEQ_SUM) ? sum_mask_q : ind_mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         ind_addr_q <= '0;
         sum_addr_q <= '0;
         ind_mask_q <= '0;
         sum_mask_q <= '0;
         isc_q      <= '0;
      end else begin
         state_q <= state_d;
         if (start_seq) begin
            ind_addr_q <= ind_addr;
            ind_mask_q <= ind_mask;
            sum_addr_q <= sum_addr;
            sum_mask_q <= sum_mask;
            isc_q      <= isc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_isc    <= '0;
         err_valid  <= 1'b0;
         err_code   <= '0;
         err_handle <= '0;
         err_addr   <= '0;
         err_detail <= '0;
      end else begin
         irq_valid <= step_done && (state_q == SEQ_SUM) && !rmw_err && (rmw_old == 8'h00);
         irq_isc   <= isc_q;
         err_valid <= no_dev || (step_done && rmw_err);
         if (no_dev) begin
            err_code   <= NOMSI_CODE;
            err_handle <= idx;
            err_addr   <= wr_addr;
            err_detail <= DET_W'(vec) << VEC_SHIFT;
         end else if (step_done && rmw_err) begin
            err_code   <= AIRERR_CODE;
            err_handle <= '0;
            err_addr   <= '0;
            err_detail <= '0;
         end
      end
   end
endmodule

// File: rtl/msi_bit_router.sv
module msi_bit_router #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int VEC_BITS  = 11,
   parameter int OFF_W     = 16,
   parameter int ISC_W     = 3,
   parameter int RD_W      = 32,
   parameter int VEC_SHIFT = 16,
   parameter logic [15:0] NOMSI_CODE  = 16'h0001,
   parameter logic [15:0] AIRERR_CODE = 16'h0002
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_valid,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       rd_en,
   output logic                       rd_valid,
   output logic [RD_W-1:0]            rd_data,
   input  logic                       dev_present,
   input  logic                       dev_enabled,
   input  logic [ADDR_W-1:0]          ind_base,
   input  logic [OFF_W-1:0]           ind_off,
   input  logic [ADDR_W-1:0]          sum_base,
   input  logic [OFF_W-1:0]           sum_off,
   input  logic [ISC_W-1:0]           isc,
   output logic                       busy,
   output logic                       rmw_req,
   output logic [ADDR_W-1:0]          rmw_addr,
   output logic [7:0]                 rmw_mask,
   input  logic                       rmw_ack,
   input  logic [7:0]                 rmw_old,
   input  logic                       rmw_err,
   output logic                       irq_valid,
   output logic [ISC_W-1:0]           irq_isc,
   output logic                       err_valid,
   output logic [15:0]                err_code,
   output logic [DATA_W-VEC_BITS-1:0] err_handle,
   output logic [ADDR_W-1:0]          err_addr,
   output logic [31:0]                err_detail
);
   localparam int IDX_W   = DATA_W - VEC_BITS;
   localparam int DET_W   = 32;
   localparam int N_ARRAY = 2;

   generate
      if (VEC_BITS < 1 || VEC_BITS >= DATA_W) begin : g_bad_split
         $error("VEC_BITS must lie inside the data word");
      end
      if (VEC_SHIFT + VEC_BITS > DET_W) begin : g_bad_shift
         $error("vector does not fit in the error detail word");
      end
      if (ADDR_W < 4 || OFF_W < 3) begin : g_bad_width
         $error("address or offset width too small");
      end
   endgenerate

   logic [IDX_W-1:0]    idx;
   logic [VEC_BITS-1:0] vec;

   msi_rt_split #(.DATA_W(DATA_W), .VEC_BITS(VEC_BITS)) u_split (
      .data (wr_data),
      .idx  (idx),
      .vec  (vec)
   );

   // Array 0: per-vector indicator; array 1: summary (offset only)
   logic [ADDR_W-1:0] loc_base [N_ARRAY];
   logic [OFF_W-1:0]  loc_off  [N_ARRAY];
   logic [ADDR_W-1:0] loc_addr [N_ARRAY];
   logic [7:0]        loc_mask [N_ARRAY];

   assign loc_base[0] = ind_base;
   assign loc_off[0]  = ind_off;
   assign loc_base[1] = sum_base;
   assign loc_off[1]  = sum_off;

   for (genvar g = 0; g < N_ARRAY; g++) begin : g_loc
      msi_rt_locate #(
         .ADDR_W   (ADDR_W),
         .OFF_W    (OFF_W),
         .VEC_BITS (VEC_BITS),
         .ADD_VEC  (g == 0)
      ) u_loc (
         .base      (loc_base[g]),
         .off       (loc_off[g]),
         .vec       (vec),
         .byte_addr (loc_addr[g]),
         .mask      (loc_mask[g])
      );
   end

   msi_rt_seq #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .VEC_BITS    (VEC_BITS),
      .ISC_W       (ISC_W),
      .DET_W       (DET_W),
      .VEC_SHIFT   (VEC_SHIFT),
      .NOMSI_CODE  (NOMSI_CODE),
      .AIRERR_CODE (AIRERR_CODE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_addr     (wr_addr),
      .idx         (idx),
      .vec         (vec),
      .dev_present (dev_present),
      .dev_enabled (dev_enabled),
      .ind_addr    (loc_addr[0]),
      .ind_mask    (loc_mask[0]),
      .sum_addr    (loc_addr[1]),
      .sum_mask    (loc_mask[1]),
      .isc         (isc),
      .busy        (busy),
      .rmw_req     (rmw_req),
      .rmw_addr    (rmw_addr),
      .rmw_mask    (rmw_mask),
      .rmw_ack     (rmw_ack),
      .rmw_old     (rmw_old),
      .rmw_err     (rmw_err),
      .irq_valid   (irq_valid),
      .irq_isc     (irq_isc),
      .err_valid   (err_valid),
      .err_code    (err_code),
      .err_handle  (err_handle),
      .err_addr    (err_addr),
      .err_detail  (err_detail)
   );

   // Control window reads: always all ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? '1 : '0;
      end
   end
endmodule

// File: rtl/msi_bit_router_chk.sv
module msi_bit_router_chk #(
   parameter int ADDR_W = 32,
   parameter int RD_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              dev_present,
   input logic              dev_enabled,
   input logic              rd_en,
   input logic              rd_valid,
   input logic [RD_W-1:0]   rd_data,
   input logic              busy,
   input logic              rmw_req,
   input logic [ADDR_W-1:0] rmw_addr,
   input logic [7:0]        rmw_mask,
   input logic              rmw_ack,
   input logic [7:0]        rmw_old,
   input logic              rmw_err,
   input logic              irq_valid,
   input logic              err_valid
);
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_req && !rmw_ack |=> rmw_req && $stable(rmw_addr) && $stable(rmw_mask));

   p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_req |-> $countones(rmw_mask) == 1);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rmw_req ##1 irq_valid |-> 1'b0);

   p_irq_old_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> $past(rmw_ack && !rmw_err && rmw_old == 8'h00));

   p_no_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !busy && !dev_present |=> !rmw_req && err_valid);

   p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !busy && dev_present && !dev_enabled |=> !rmw_req && !err_valid && !irq_valid);

   p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !busy && dev_present && dev_enabled |=> busy && rmw_req);

   p_irq_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_valid && err_valid));

   p_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid && (&rd_data));
endmodule

bind msi_bit_router msi_bit_router_chk #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .dev_present (dev_present),
   .dev_enabled (dev_enabled),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .busy        (busy),
   .rmw_req     (rmw_req),
   .rmw_addr    (rmw_addr),
   .rmw_mask    (rmw_mask),
   .rmw_ack     (rmw_ack),
   .rmw_old     (rmw_old),
   .rmw_err     (rmw_err),
   .irq_valid   (irq_valid),
   .err_valid   (err_valid)
);

// File: tb/msi_bit_router_tb.sv
module msi_bit_router_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;
   localparam int MEM_BYTES  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        dev_present = 1'b0, dev_enabled = 1'b0;
   logic [31:0] ind_base = '0, sum_base = '0;
   logic [15:0] ind_off = '0, sum_off = '0;
   logic [2:0]  isc = '0;
   logic        busy, rmw_req;
   logic [31:0] rmw_addr;
   logic [7:0]  rmw_mask;
   logic        rmw_ack = 1'b0;
   logic [7:0]  rmw_old = '0;
   logic        rmw_err = 1'b0;
   logic        irq_valid;
   logic [2:0]  irq_isc;
   logic        err_valid;
   logic [15:0] err_code;
   logic [20:0] err_handle;
   logic [31:0] err_addr, err_detail;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_bit_router u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
      .dev_present(dev_present), .dev_enabled(dev_enabled),
      .ind_base(ind_base), .ind_off(ind_off), .sum_base(sum_base), .sum_off(sum_off), .isc(isc),
      .busy(busy), .rmw_req(rmw_req), .rmw_addr(rmw_addr), .rmw_mask(rmw_mask),
      .rmw_ack(rmw_ack), .rmw_old(rmw_old), .rmw_err(rmw_err),
      .irq_valid(irq_valid), .irq_isc(irq_isc), .err_valid(err_valid), .err_code(err_code),
      .err_handle(err_handle), .err_addr(err_addr), .err_detail(err_detail)
   );

   int checks = 0;
   int fails  = 0;

   // Scoreboard items: kind 0 = OR op {addr,mask}, 1 = irq {isc}, 2 = error event
   typedef struct packed {
      logic [1:0]   kind;
      logic [127:0] body;
   } item_t;

   item_t      exp_q[$];
   logic [7:0] mem     [MEM_BYTES];
   logic [7:0] ref_mem [MEM_BYTES];
   string      cur_tag = "";

   function automatic string kname(input logic [1:0] k);
      return (k == 2'd0) ? "OR" : (k == 2'd1) ? "IRQ" : "ERR";
   endfunction

   task automatic check_item(input item_t got);
      item_t e;
      checks++;
      if (exp_q.size() == 0) begin
         fails++;
         $display("FAIL %s: unexpected %s body=%h, expected nothing", cur_tag, kname(got.kind), got.body);
      end else begin
         e = exp_q.pop_front();
         if (e !== got) begin
            fails++;
            $display("FAIL %s: got %s %h, expected %s %h", cur_tag,
                     kname(got.kind), got.body, kname(e.kind), e.body);
         end
      end
   endtask

   task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor and memory responder, both on the inactive edge
   int wait_cnt = 0;
   always @(negedge clk) begin
      item_t it;
      if (rst_n) begin
         if (err_valid) begin
            it.kind = 2'd2;
            it.body = {32'd0, err_code, 11'd0, err_handle, err_addr, err_detail};
            check_item(it);
         end
         if (irq_valid) begin
            it.kind = 2'd1;
            it.body = 128'(irq_isc);
            check_item(it);
         end
      end
      rmw_ack = 1'b0;
      rmw_err = 1'b0;
      rmw_old = 8'h00;
      if (rst_n && rmw_req) begin
         if (wait_cnt == LAT) begin
            wait_cnt = 0;
            it.kind = 2'd0;
            it.body = 128'({rmw_addr, rmw_mask});
            check_item(it);
            rmw_ack = 1'b1;
            if (rmw_addr >= MEM_BYTES) begin
               rmw_err = 1'b1;
               rmw_old = 8'hFF;
            end else begin
               rmw_old = mem[rmw_addr[5:0]];
               mem[rmw_addr[5:0]] = mem[rmw_addr[5:0]] | rmw_mask;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   // Driver: predicts the items from the requirements and applies the write
   task automatic push(input logic [1:0] k, input logic [127:0] b);
      item_t it;
      it.kind = k;
      it.body = b;
      exp_q.push_back(it);
   endtask

   task automatic predict_or(input logic [31:0] a, input logic [7:0] m, output logic fault, output logic [7:0] old);
      push(2'd0, 128'({a, m}));
      fault = (a >= MEM_BYTES);
      old   = 8'hFF;
      if (!fault) begin
         old = ref_mem[a[5:0]];
         ref_mem[a[5:0]] = ref_mem[a[5:0]] | m;
      end
   endtask

   task automatic msi_write(input string tag, input logic [31:0] data, input logic [31:0] addr,
                            input logic pres, input logic en,
                            input logic [31:0] ib, input logic [15:0] io,
                            input logic [31:0] sb, input logic [15:0] so, input logic [2:0] ic);
      logic [10:0] v;
      logic [20:0] ix;
      logic [16:0] n;
      logic        flt;
      logic [7:0]  old;
      cur_tag = tag;
      v  = data[10:0];          // R1 split
      ix = data[31:11];
      if (!pres) begin
         push(2'd2, {32'd0, 16'h0001, 11'd0, ix, addr, 32'(v) << 16});
      end else if (en) begin
         n = 17'(io) + 17'(v);   // R4 indicator location
         predict_or(ib + 32'(n >> 3), 8'h80 >> n[2:0], flt, old);
         if (flt) push(2'd2, {32'd0, 16'h0002, 11'd0, 21'd0, 32'd0, 32'd0});
         predict_or(sb + 32'(so >> 3), 8'h80 >> so[2:0], flt, old);  // R5 summary location
         if (flt) push(2'd2, {32'd0, 16'h0002, 11'd0, 21'd0, 32'd0, 32'd0});
         else if (old == 8'h00) push(2'd1, 128'(ic));
      end
      @(negedge clk);
      wr_data = data; wr_addr = addr; dev_present = pres; dev_enabled = en;
      ind_base = ib; ind_off = io; sum_base = sb; sum_off = so; isc = ic;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic settle(input string tag);
      int guard = 0;
      while (busy && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      repeat (3) @(negedge clk);
      check_val({tag, " all expected items seen"}, 64'(exp_q.size()), 64'd0);
      exp_q.delete();
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM_BYTES; i++) begin
         mem[i] = 8'h00;
         ref_mem[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      // R11 reset state
      check_val("R11 rmw_req", 64'(rmw_req), 0);
      check_val("R11 irq/err/rd/busy", 64'({irq_valid, err_valid, rd_valid, busy}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 R5 R7: bit 8 -> byte 1 mask 80; summary clear -> interrupt
      msi_write("R4 R7 first vector", 32'h0000_0003, 32'h100, 1, 1, 0, 5, 32, 0, 3'd3);
      settle("R7");
      // R7: summary already set -> no interrupt
      msi_write("R7 summary set", 32'h0000_0003, 32'h100, 1, 1, 0, 5, 32, 0, 3'd3);
      settle("R7 no irq");
      // R4 bit 15 -> mask 01; R5 summary offset 9 -> byte 33 mask 40
      msi_write("R4 R5 low mask", 32'h0000_080A, 32'h104, 1, 1, 0, 5, 32, 9, 3'd5);
      settle("R5");
      // R8 indicator fault, summary still done (byte 33 already 40 -> no irq)
      msi_write("R8 ind fault", 32'h0000_07FF, 32'h108, 1, 1, 0, 0, 32, 10, 3'd1);
      settle("R8 ind");
      // R8 summary fault: vector 20 -> byte 2 mask 08, summary out of range
      msi_write("R8 sum fault", 32'h0000_0014, 32'h10C, 1, 1, 0, 0, 100, 0, 3'd2);
      settle("R8 sum");
      // R2 R1 missing device
      msi_write("R2 R1 no device", {21'h12345, 11'h7AB}, 32'hDEAD_0000, 0, 0, 0, 0, 0, 0, 3'd0);
      settle("R2");
      // R3 disabled device: nothing; then check memory unaffected via next write's old byte
      msi_write("R3 disabled", 32'h0000_0030, 32'h110, 1, 0, 0, 0, 40, 0, 3'd4);
      check_val("R3 no request", 64'(rmw_req), 0);
      settle("R3");
      // after the ignored write, byte 40 must still be clear -> interrupt (R3)
      msi_write("R3 follow-up", 32'h0000_0030, 32'h110, 1, 1, 0, 0, 40, 0, 3'd4);
      settle("R3 follow");
      // R9 write during busy ignored; R6 ordering covered by scoreboard
      msi_write("R9 R6 first", 32'h0000_0021, 32'h120, 1, 1, 8, 0, 48, 3, 3'd6);
      check_val("R9 busy", 64'(busy), 1);
      wr_data = 32'h0000_0022; dev_present = 1; dev_enabled = 1; ind_base = 16;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      settle("R9");
      // R10 control window read
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check_val("R10 rd_valid", 64'(rd_valid), 1);
      check_val("R10 rd_data", 64'(rd_data), 64'hFFFF_FFFF);
      @(negedge clk);
      check_val("R10 rd_valid drop", 64'(rd_valid), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule